// File: doc/BRIEF.md
# Staged Channel-Interleave Address Dehasher

Memory controllers that spread traffic over several channels often pick the channel from a few low address bits. Those bits are XOR-folded with higher address bits, so that large power-of-two strides do not all land on one channel. This block reverses that folding. It recovers the plain physical address from the hashed one.

A request carries a 64-bit address, the position of the first interleave bit, a three-bit granule-enable vector and a channel-count mode. The block runs up to three correction stages in a fixed order. Each stage may toggle one low address bit. Each stage sees the address as already corrected by the stages ahead of it.

The result is registered and returned one cycle later with an error flag, over a valid/ready handshake. Illegal configurations are flagged. In that case the address passes through without any correction.

Top module: `ilv_dehash`

## Requirements
- R1: `in_start_bit` must be 8 or 9. Any other value gives `out_err`=1, and `out_addr[47:0]` equals `in_addr[47:0]` untouched.
- R2: Stage 1 forms the parity of four terms:
  - address bit 14, always included;
  - bit 18 AND `in_gran_en[0]` (64 KiB);
  - bit 23 AND `in_gran_en[1]` (2 MiB);
  - bit 32 AND `in_gran_en[2]` (1 GiB).
  When the parity is 1, stage 1 toggles the address bit at position `in_start_bit`.
- R3: Stage 2 forms the parity of bit 16 AND `in_gran_en[0]`, bit 21 AND `in_gran_en[1]`, and bit 30 AND `in_gran_en[2]`. When the parity is 1, it toggles bit 12.
- R4: Stage 3 forms the parity of bit 17 AND `in_gran_en[0]`, bit 22 AND `in_gran_en[1]`, and bit 31 AND `in_gran_en[2]`. When the parity is 1, it toggles bit 13.
- R5: The mode selects which stages run:
  - `in_mode`=0 (two channels): stage 1 only; bits 12 and 13 pass unchanged.
  - `in_mode`=1 (four channels): stages 1 and 2.
  - `in_mode`=2 (eight channels): all three stages.
- R6: `in_mode`=3 is illegal. It gives `out_err`=1 and passes `out_addr[47:0]` through unchanged.
- R7: A request accepted on a clock edge (`in_valid` and `in_ready` both high) has its result, with `out_valid`=1, presented from that same edge onward.
- R8: While `out_valid`=1 and `out_ready`=0, `out_addr` and `out_err` hold steady and `in_ready`=0. Otherwise `in_ready`=1.
- R9: `out_addr[63:48]` is always zero.
- R10: After reset, `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_addr | input | 64 | Hashed address |
| in_start_bit | input | 6 | Position of the first interleave bit |
| in_mode | input | 2 | Channel-count mode |
| in_gran_en | input | 3 | Granule enables: bit0 64 KiB, bit1 2 MiB, bit2 1 GiB |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 64 | Dehashed address |
| out_err | output | 1 | Illegal configuration |

## Verification
The datapath is combinational up to a single result register. A wrong tap, a wrong enable gate or a wrong stage count therefore shows up as a single toggled bit among bits 8, 9, 12 and 13 of the very next result.

A handshake fault is equally quick to surface. A lost or duplicated result, or a held result that changes, is visible within one cycle of the stall or of its release.

The vectors isolate each tap on its own and pair taps so that they cancel. They run the same stimulus under different modes, so that a stage wired to the wrong mode is exposed.

// File: rtl/ilv_dehash_pkg.sv
package ilv_dehash_pkg;

    localparam int BUS_W  = 64;  // width of the address ports
    localparam int PA_W   = 48;  // meaningful physical address bits
    localparam int SB_W   = 6;   // width of the start-bit selector
    localparam int NSTG   = 3;   // correction stages available
    localparam int CNT_W  = $clog2(NSTG + 1);

    localparam int START_LO = 8;  // legal start positions
    localparam int START_HI = 9;
    localparam int FIXED_TAP = 14; // always-on term of the first stage

    typedef enum logic [1:0] {
        MODE_2CH = 2'd0,
        MODE_4CH = 2'd1,
        MODE_8CH = 2'd2,
        MODE_BAD = 2'd3
    } ilv_mode_e;

    typedef struct packed {
        logic g1g;
        logic g2m;
        logic g64k;
    } gran_en_t;

    typedef struct packed {
        logic [PA_W-1:0] addr;
        logic            err;
    } result_t;

    // Tap positions per stage (stage index 0..2).
    function automatic int tap_64k(input int s);
        return (s == 0) ? 18 : 15 + s;
    endfunction

    function automatic int tap_2m(input int s);
        return (s == 0) ? 23 : 20 + s;
    endfunction

    function automatic int tap_1g(input int s);
        return (s == 0) ? 32 : 29 + s;
    endfunction

    // Fixed target bit of stages after the first.
    function automatic int fixed_target(input int s);
        return 11 + s;
    endfunction

    function automatic logic [CNT_W-1:0] stages_for_mode(input ilv_mode_e m);
        case (m)
            MODE_2CH: return CNT_W'(1);
            MODE_4CH: return CNT_W'(2);
            MODE_8CH: return CNT_W'(3);
            default:  return CNT_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/ilv_dehash_cfg.sv
module ilv_dehash_cfg
    import ilv_dehash_pkg::*;
(
    input  logic [SB_W-1:0]  start_bit,
    input  ilv_mode_e        mode,
    output logic             cfg_err,
    output logic [CNT_W-1:0] n_stages
);
    logic pos_ok;
    logic mode_ok;

    always_comb begin
        pos_ok   = (start_bit == SB_W'(START_LO)) || (start_bit == SB_W'(START_HI));
        mode_ok  = (mode != MODE_BAD);
        cfg_err  = !(pos_ok && mode_ok);
        n_stages = cfg_err ? '0 : stages_for_mode(mode);
    end
endmodule

// File: rtl/ilv_dehash_stage.sv
module ilv_dehash_stage
    import ilv_dehash_pkg::*;
#(
    parameter int IDX = 0,
    parameter int AW  = PA_W
) (
    input  logic [AW-1:0]   addr_i,
    input  logic [SB_W-1:0] start_bit,
    input  gran_en_t        en,
    input  logic            active,
    output logic [AW-1:0]   addr_o
);
    localparam int T64 = tap_64k(IDX);
    localparam int T2M = tap_2m(IDX);
    localparam int T1G = tap_1g(IDX);

    logic            gated_par;
    logic            par;
    logic [AW-1:0]   flip_sel;

    always_comb begin
        gated_par = (addr_i[T64] & en.g64k)
                  ^ (addr_i[T2M] & en.g2m)
                  ^ (addr_i[T1G] & en.g1g);
    end

    generate
        if (IDX == 0) begin : g_first
            assign par      = gated_par ^ addr_i[FIXED_TAP];
            assign flip_sel = AW'(1) << start_bit;
        end else begin : g_fixed
            logic unused_sb;
            assign unused_sb = ^start_bit;
            assign par       = gated_par;
            assign flip_sel  = AW'(1) << fixed_target(IDX);
        end
    endgenerate

    assign addr_o = (active && par) ? (addr_i ^ flip_sel) : addr_i;
endmodule

// File: rtl/ilv_dehash.sv
module ilv_dehash
    import ilv_dehash_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BUS_W-1:0]  in_addr,
    input  logic [SB_W-1:0]   in_start_bit,
    input  logic [1:0]        in_mode,
    input  logic [2:0]        in_gran_en,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BUS_W-1:0]  out_addr,
    output logic              out_err
);
    logic              cfg_err;
    logic [CNT_W-1:0]  n_stages;
    gran_en_t          en;
    logic [PA_W-1:0]   chain [NSTG+1];
    logic              unused_hi;
    result_t           res_d;
    result_t           res_q;
    logic              valid_q;
    logic              take;

    assign en        = gran_en_t'(in_gran_en);
    assign unused_hi = ^in_addr[BUS_W-1:PA_W];
    assign chain[0]  = in_addr[PA_W-1:0];

    ilv_dehash_cfg u_cfg (
        .start_bit (in_start_bit),
        .mode      (ilv_mode_e'(in_mode)),
        .cfg_err   (cfg_err),
        .n_stages  (n_stages)
    );

    generate
        for (genvar s = 0; s < NSTG; s++) begin : g_stage
            logic act;
            assign act = (n_stages > CNT_W'(s));
            ilv_dehash_stage #(.IDX(s), .AW(PA_W)) u_stg (
                .addr_i    (chain[s]),
                .start_bit (in_start_bit),
                .en        (en),
                .active    (act),
                .addr_o    (chain[s+1])
            );
        end
    endgenerate

    assign res_d.addr = chain[NSTG];
    assign res_d.err  = cfg_err;

    assign in_ready = !valid_q || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            if (take) begin
                valid_q <= 1'b1;
                res_q   <= res_d;
            end else if (out_ready) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign out_valid = valid_q;
    assign out_addr  = {{(BUS_W-PA_W){1'b0}}, res_q.addr};
    assign out_err   = res_q.err;
endmodule

// File: rtl/ilv_dehash_chk.sv
module ilv_dehash_chk
    import ilv_dehash_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [BUS_W-1:0] in_addr,
    input logic [SB_W-1:0]  in_start_bit,
    input logic [1:0]       in_mode,
    input logic             out_valid,
    input logic             out_ready,
    input logic [BUS_W-1:0] out_addr,
    input logic             out_err
);
    logic acc;
    logic pos_bad;
    assign acc     = in_valid && in_ready;
    assign pos_bad = (in_start_bit != SB_W'(START_LO)) && (in_start_bit != SB_W'(START_HI));

    p_latency_r7: assert property (@(posedge clk) disable iff (rst)
        acc |=> out_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_err)));

    p_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    p_upper_zero_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_addr[BUS_W-1:PA_W] == '0));

    p_badpos_r1: assert property (@(posedge clk) disable iff (rst)
        (acc && pos_bad) |=> (out_err && out_addr[PA_W-1:0] == $past(in_addr[PA_W-1:0])));

    p_badmode_r6: assert property (@(posedge clk) disable iff (rst)
        (acc && in_mode == 2'd3) |=> (out_err && out_addr[PA_W-1:0] == $past(in_addr[PA_W-1:0])));

    p_twochan_r5: assert property (@(posedge clk) disable iff (rst)
        (acc && in_mode == 2'd0 && !pos_bad) |=>
            (!out_err && out_addr[13:12] == $past(in_addr[13:12])));
endmodule

bind ilv_dehash ilv_dehash_chk chk_i (.*);

// File: tb/ilv_dehash_tb_top.sv
module ilv_dehash_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [63:0] in_addr;
    logic [5:0]  in_start_bit;
    logic [1:0]  in_mode;
    logic [2:0]  in_gran_en;
    logic        out_valid;
    logic        out_ready;
    logic [63:0] out_addr;
    logic        out_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    ilv_dehash dut_i (.*);

    typedef struct packed {
        logic [63:0] a;
        logic [5:0]  sb;
        logic [1:0]  md;
        logic [2:0]  en;
        logic [47:0] flip;
        logic        err;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_0000_0000_0000, 6'd8, 2'd2, 3'd7, 48'h0000, 1'b0}, // R4 no taps
        '{64'h0000_0000_0000_4000, 6'd8, 2'd0, 3'd0, 48'h0100, 1'b0}, // R2 fixed tap
        '{64'h0000_0000_0000_4000, 6'd9, 2'd0, 3'd0, 48'h0200, 1'b0}, // R2 start 9
        '{64'h0000_0000_0004_0000, 6'd8, 2'd0, 3'd1, 48'h0100, 1'b0}, // R2 64K tap
        '{64'h0000_0000_0004_0000, 6'd8, 2'd0, 3'd0, 48'h0000, 1'b0}, // R11-like gate off (R2)
        '{64'h0000_0000_0080_4000, 6'd8, 2'd0, 3'd2, 48'h0000, 1'b0}, // R2 cancel
        '{64'h0000_0001_0000_0000, 6'd9, 2'd0, 3'd4, 48'h0200, 1'b0}, // R2 1G tap
        '{64'h0000_0000_0001_0000, 6'd8, 2'd1, 3'd1, 48'h1000, 1'b0}, // R3
        '{64'h0000_0000_0001_0000, 6'd8, 2'd0, 3'd1, 48'h0000, 1'b0}, // R5 2ch skips stage 2
        '{64'h0000_0000_4020_0000, 6'd8, 2'd1, 3'd6, 48'h0000, 1'b0}, // R3 cancel
        '{64'h0000_0000_4000_0000, 6'd8, 2'd1, 3'd4, 48'h1000, 1'b0}, // R3 1G
        '{64'h0000_0000_0002_0000, 6'd8, 2'd2, 3'd1, 48'h2000, 1'b0}, // R4
        '{64'h0000_0000_0002_0000, 6'd8, 2'd1, 3'd1, 48'h0000, 1'b0}, // R5 4ch skips stage 3
        '{64'h0000_0000_8040_4000, 6'd8, 2'd2, 3'd2, 48'h2100, 1'b0}, // R4 + R2
        '{64'hFFFF_FFFF_FFFF_FFFF, 6'd8, 2'd2, 3'd7, 48'h3000, 1'b0}, // R5 all stages, R9
        '{64'hFF00_0000_0000_4000, 6'd10, 2'd0, 3'd0, 48'h0000, 1'b1}, // R1 pos 10
        '{64'h0000_0000_0000_4000, 6'd7, 2'd2, 3'd7, 48'h0000, 1'b1}, // R1 pos 7
        '{64'h0000_0000_0001_4000, 6'd8, 2'd3, 3'd7, 48'h0000, 1'b1}, // R6 bad mode
        '{64'hABCD_0000_0000_4000, 6'd8, 2'd0, 3'd0, 48'h0100, 1'b0}, // R9 upper zero
        '{64'h0000_0000_0000_4100, 6'd8, 2'd0, 3'd0, 48'h0100, 1'b0}  // R2 clears bit
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_addr      = v.a;
        in_start_bit = v.sb;
        in_mode      = v.md;
        in_gran_en   = v.en;
    endtask

    function automatic logic [63:0] expect_addr(input vec_t v);
        return {16'h0, v.a[47:0] ^ v.flip};
    endfunction

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=<20000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        vec_t va;
        vec_t vb;
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
        drive(VECS[0]);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 out_valid after reset", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R10 in_ready after reset", 64'(in_ready), 64'd1);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            chk(out_valid == 1'b1, $sformatf("R7 valid vec %0d", i), 64'(out_valid), 64'd1);
            chk(out_addr == expect_addr(VECS[i]) && out_err == VECS[i].err,
                $sformatf("R1-6/R9 vec %0d err=%0b/%0b", i, out_err, VECS[i].err),
                out_addr, expect_addr(VECS[i]));
        end
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 drains when ready", 64'(out_valid), 64'd0);

        // R8 backpressure: result held, input refused, then released.
        va = VECS[1];
        vb = VECS[7];
        out_ready = 1'b0;
        drive(va); in_valid = 1'b1;
        @(negedge clk);
        drive(vb);
        for (int k = 0; k < 3; k++) begin
            chk(out_valid && out_addr == expect_addr(va), "R8 held result", out_addr, expect_addr(va));
            chk(in_ready == 1'b0, "R8 in_ready low while held", 64'(in_ready), 64'd0);
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && out_addr == expect_addr(vb), "R8 next after release", out_addr, expect_addr(vb));
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 empty after release", 64'(out_valid), 64'd0);

        // R10 reset while a result is held.
        out_ready = 1'b0;
        drive(va); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(out_valid == 1'b0, "R10 reset clears held", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R10 ready after reset", 64'(in_ready), 64'd1);
        out_ready = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule